// File: doc/BRIEF.md
# Compare-Value Timer Channel with Counter Offset

This block is one timer channel for a single core. It takes a free-running 64-bit system count and subtracts a programmable 64-bit offset to form its own counter view. A physical timer uses an offset of zero. A virtual timer is the same block with the offset set to some other value. The channel holds a 64-bit compare value and drives a level interrupt once the counter view has reached that value, provided the channel is enabled and not masked.

Software reaches the compare register in two ways. The first is as an absolute 64-bit value, split into low and high words. The second is as a signed 32-bit relative value measured from the current counter view. Reading the relative value gives the distance still to go, and the result goes negative once the deadline has passed. The status bit in the control word shows whether the condition is met, whatever the mask setting. The interrupt line also obeys the mask.

The register port is a simple single-cycle 32-bit write port plus a combinational read port. Writes take effect at the clock edge, and the condition follows at once from the updated state.

Top module: `cmp_timer`

## Requirements
- R1: After reset the control word, the compare value and the offset are all zero, and `irq_o` is low.
- R2: The counter view is `sys_count_i - offset` modulo 2^64. It reads at address 6 (low word) and address 7 (high word). The offset is written at address 4 (low word) and address 5 (high word).
- R3: The control word sits at address 0. Bit 0 is enable and bit 1 is mask, and both can be written. Bit 2 is the condition status and is read-only, so writes to it are ignored. Bits 31:3 read as zero.
- R4: Status bit 2 reads 1 exactly when enable is 1 and the counter view is greater than or equal to the compare value. While enable is 0 it reads 0.
- R5: `irq_o` is high exactly when enable is 1, mask is 0 and the status condition holds.
- R6: A read of address 3 returns the compare value minus the counter view, truncated to 32 bits.
- R7: A write of W to address 3 sets the compare value to the counter view plus W sign-extended to 64 bits. The absolute compare value is written at address 1 (low word) and address 2 (high word).
- R8: After a write to the compare value, the offset or the control word, both status and `irq_o` reflect the new state in the cycle that follows the write edge. There is no extra delay.
- R9: The comparison is unsigned over 64 bits. A compare value with bit 63 set stays ahead of any view below 2^63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sys_count_i | input | 64 | System count |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational on the address |
| irq_o | output | 1 | Level interrupt |

## Verification
The bound checker runs on every cycle. It checks that the interrupt never rises while the channel is disabled or masked, that it is always high when enabled, unmasked and the view has reached the compare value, and that it is never high while the view is still below the compare value. It also checks how control writes and relative-value writes land in state. Only the bench scenarios can show the exact read values. These are the wrapped relative value once a deadline has passed, the 64-bit offset wrap, the read-only status bit, and the unsigned behaviour when bit 63 of the compare value is set. The bench reaches all of these through the register port.

// File: rtl/cmp_timer_pkg.sv
package cmp_timer_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CMP_LO = 3'd1,
    A_CMP_HI = 3'd2,
    A_TVAL   = 3'd3,
    A_OFF_LO = 3'd4,
    A_OFF_HI = 3'd5,
    A_VIEW_LO = 3'd6,
    A_VIEW_HI = 3'd7
  } reg_addr_e;

  localparam int unsigned CTRL_EN_BIT  = 0;
  localparam int unsigned CTRL_MSK_BIT = 1;
  localparam int unsigned CTRL_ST_BIT  = 2;
endpackage

// File: rtl/cmp_timer_view.sv
module cmp_timer_view #(
  parameter int unsigned CW = 64
) (
  input  logic [CW-1:0] sys_i,
  input  logic [CW-1:0] off_i,
  output logic [CW-1:0] view_o
);
  assign view_o = sys_i - off_i;
endmodule

// File: rtl/cmp_timer_regs.sv
module cmp_timer_regs
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [CW-1:0]     view_i,
  output logic              en_o,
  output logic              imask_o,
  output logic [CW-1:0]     cmp_o,
  output logic [CW-1:0]     off_o
);
  logic [CW-1:0] tval_sext;
  assign tval_sext = {{DW{wdata_i[DW-1]}}, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= 1'b0;
      imask_o <= 1'b0;
      cmp_o   <= '0;
      off_o   <= '0;
    end else if (we_i) begin
      case (reg_addr_e'(addr_i))
        A_CTRL: begin
          en_o    <= wdata_i[CTRL_EN_BIT];
          imask_o <= wdata_i[CTRL_MSK_BIT];
        end
        A_CMP_LO: cmp_o[DW-1:0]  <= wdata_i;
        A_CMP_HI: cmp_o[CW-1:DW] <= wdata_i;
        A_TVAL:   cmp_o          <= view_i + tval_sext;
        A_OFF_LO: off_o[DW-1:0]  <= wdata_i;
        A_OFF_HI: off_o[CW-1:DW] <= wdata_i;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cmp_timer_cond.sv
module cmp_timer_cond #(
  parameter int unsigned CW = 64
) (
  input  logic          en_i,
  input  logic          imask_i,
  input  logic [CW-1:0] view_i,
  input  logic [CW-1:0] cmp_i,
  output logic          status_o,
  output logic          irq_o
);
  assign status_o = en_i & (view_i >= cmp_i);
  assign irq_o    = status_o & ~imask_i;
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer
  import cmp_timer_pkg::*;
#(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CW-1:0]     sys_count_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  output logic              irq_o
);
  logic          ctrl_en, ctrl_msk, cond_st;
  logic [CW-1:0] cmp_q, off_q, view_w, tval_w;

  cmp_timer_view #(.CW(CW)) u_view (
    .sys_i (sys_count_i),
    .off_i (off_q),
    .view_o(view_w)
  );

  cmp_timer_regs #(.DW(DW)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (reg_we_i),
    .addr_i (reg_addr_i),
    .wdata_i(reg_wdata_i),
    .view_i (view_w),
    .en_o   (ctrl_en),
    .imask_o(ctrl_msk),
    .cmp_o  (cmp_q),
    .off_o  (off_q)
  );

  cmp_timer_cond #(.CW(CW)) u_cond (
    .en_i    (ctrl_en),
    .imask_i (ctrl_msk),
    .view_i  (view_w),
    .cmp_i   (cmp_q),
    .status_o(cond_st),
    .irq_o   (irq_o)
  );

  assign tval_w = cmp_q - view_w;

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_e'(reg_addr_i))
      A_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT]  = ctrl_en;
        reg_rdata_o[CTRL_MSK_BIT] = ctrl_msk;
        reg_rdata_o[CTRL_ST_BIT]  = cond_st;
      end
      A_CMP_LO:  reg_rdata_o = cmp_q[DW-1:0];
      A_CMP_HI:  reg_rdata_o = cmp_q[CW-1:DW];
      A_TVAL:    reg_rdata_o = tval_w[DW-1:0];
      A_OFF_LO:  reg_rdata_o = off_q[DW-1:0];
      A_OFF_HI:  reg_rdata_o = off_q[CW-1:DW];
      A_VIEW_LO: reg_rdata_o = view_w[DW-1:0];
      A_VIEW_HI: reg_rdata_o = view_w[CW-1:DW];
      default: ;
    endcase
  end
endmodule

// File: rtl/cmp_timer_chk.sv
module cmp_timer_chk #(
  parameter int unsigned DW = 32,
  localparam int unsigned CW = 2 * DW
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic [2:0]    addr_i,
  input logic [DW-1:0] wdata_i,
  input logic          en_i,
  input logic          imask_i,
  input logic [CW-1:0] cmp_i,
  input logic [CW-1:0] view_i,
  input logic          irq_i
);
  a_r5_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> (en_i && !imask_i));

  a_r4_irq_when_reached: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !imask_i && (view_i >= cmp_i)) |-> irq_i);

  a_r9_no_irq_before_cmp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (view_i < cmp_i) |-> !irq_i);

  a_r3_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd0) |=> (en_i == $past(wdata_i[0]) && imask_i == $past(wdata_i[1])));

  a_r7_tval_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == 3'd3) |=>
      (cmp_i == $past(view_i) + {{DW{$past(wdata_i[DW-1])}}, $past(wdata_i)}));
endmodule

bind cmp_timer cmp_timer_chk #(.DW(DW)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (reg_we_i),
  .addr_i (reg_addr_i),
  .wdata_i(reg_wdata_i),
  .en_i   (ctrl_en),
  .imask_i(ctrl_msk),
  .cmp_i  (cmp_q),
  .view_i (view_w),
  .irq_i  (irq_o)
);

// File: tb/cmp_timer_tb.sv
module cmp_timer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] sys = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  cmp_timer u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sys_count_i(sys), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic set_sys(input logic [63:0] v);
    @(negedge clk); sys = v; #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 cmp", d, 0);
    rd(3'd4, d); chk("R1 off", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_view;
    logic [31:0] d;
    set_sys(64'h1_0000_0100);
    wr(3'd4, 32'h100);
    rd(3'd6, d); chk("R2 view lo", d, 0);
    rd(3'd7, d); chk("R2 view hi", d, 1);
    wr(3'd4, 0);
  endtask

  task automatic t_ctrl;
    logic [31:0] d;
    set_sys(64'd1000);
    wr(3'd1, 32'd1500); wr(3'd2, 0);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R3 ro status", d, 32'h3);
    chk("R3 irq", irq, 0);
  endtask

  task automatic t_fire;
    logic [31:0] d;
    wr(3'd0, 32'h1);
    chk("R4 below", irq, 0);
    set_sys(64'd1500);
    chk("R4 equal irq", irq, 1);
    rd(3'd0, d); chk("R4 status", d, 32'h5);
    set_sys(64'd1499);
    chk("R4 back below", irq, 0);
    set_sys(64'd2000);
    wr(3'd0, 32'h3);
    chk("R5 masked irq", irq, 0);
    rd(3'd0, d); chk("R5 masked status", d, 32'h7);
    wr(3'd0, 32'h2);
    rd(3'd0, d); chk("R4 disabled status", d, 32'h2);
    chk("R4 disabled irq", irq, 0);
  endtask

  task automatic t_tval_rd;
    logic [31:0] d;
    set_sys(64'd1000);
    rd(3'd3, d); chk("R6 ahead", d, 32'd500);
    set_sys(64'd1600);
    rd(3'd3, d); chk("R6 passed", d, 32'hFFFF_FF9C);
  endtask

  task automatic t_tval_wr;
    logic [31:0] d;
    wr(3'd0, 32'h1);
    set_sys(64'd5000);
    wr(3'd3, 32'hFFFF_FFF6);
    rd(3'd1, d); chk("R7 neg lo", d, 32'd4990);
    rd(3'd2, d); chk("R7 neg hi", d, 0);
    chk("R8 irq after tval", irq, 1);
    wr(3'd3, 32'd100);
    rd(3'd1, d); chk("R7 pos lo", d, 32'd5100);
    chk("R8 irq cleared", irq, 0);
  endtask

  task automatic t_offset;
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd4, 32'hFFFF_FF38);
    chk("R8 offset raises irq", irq, 1);
    wr(3'd4, 0); wr(3'd5, 0);
    chk("R8 offset clears irq", irq, 0);
  endtask

  task automatic t_unsigned;
    wr(3'd1, 0); wr(3'd2, 32'h8000_0000);
    set_sys(64'd10);
    chk("R9 high cmp no irq", irq, 0);
    set_sys(64'h8000_0000_0000_0000);
    chk("R9 reached", irq, 1);
  endtask

  initial begin
    #20; rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_view(); t_ctrl(); t_fire();
    t_tval_rd(); t_tval_wr(); t_offset(); t_unsigned();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule